// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the nanosecond timing of a requested programmed-I/O transfer mode into the clock counts that a disk controller's timing registers accept. A request carries the address setup time, the strobe active time and the full cycle time, all in nanoseconds, together with the bus clock period. It also carries the silicon revision, the index of the drive being tuned, the present flag and counts of that drive's partner, and the six low bits currently held in the setup register. The block divides each time by the clock period and rounds up. It then applies the controller's minimum and maximum limits. Surplus recovery time is moved into the active time. When two drives share one set of timing registers, each count takes the slower of the two drives' values. Last, it packs the results into the two bytes written to the controller.

Both edges of the block are valid/ready streams. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so an upstream source is held off for the whole computation. A result is presented with `out_valid` and held unchanged until `out_ready` is seen high on a clock edge. Only then does the block return to idle. The drive's own counts, taken before the partner merge, are returned with the register bytes so that the caller can keep them for later merges.

Top module: `pio_timing_calc`

## Requirements
- R1: The cycle, setup and active counts are each the time in ns divided by the clock period, rounded up. The recovery time is cycle − setup − active in ns, or 0 when that is negative. Its count is rounded up the same way. The unmerged setup count is returned on `out_setup_cnt`.
- R2: The active count is raised to at least 2. The recovery count is the larger of its own rounded-up count and (cycle count − setup count − active count, or 0 when negative), and is then raised to at least 2.
- R3: When the recovery count exceeds 17, the amount above 17 is added to the active count and recovery becomes 17. The active count is then limited to 16, so `out_active_cnt` is always within 2..16.
- R4: When the revision input is greater than 1, the recovery count is reduced by one. In every case it is then limited to 16, so `out_recovery_cnt` is within 1..16.
- R5: For drive indices 2 and 3 with `in_mate_present` high, the setup, active and recovery counts written to the register bytes are each the larger of the own and partner values. For drives 0 and 1, or with no partner, the own values are written. `out_*_cnt` always carry the own values.
- R6: `out_setup_reg` bits [5:0] equal `in_setup_keep`. Bits [7:6] encode the setup count: 4 gives 2'b00, 3 gives 2'b10, 1 or 2 gives 2'b01, and any other value gives 2'b11.
- R7: `out_timing` holds the active count's low four bits in [7:4] and the recovery count's low four bits in [3:0], so that a count of 16 is written as 0.
- R8: After a request is accepted, `in_ready` stays low and further `in_valid` activity is ignored. `out_valid` rises 4·(TIME_W+1)+9 clock edges after the accepting edge, which is 53 edges with the default parameters.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all result outputs stay unchanged.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle and able to take a request |
| in_setup_ns | input | TIME_W | Address setup time, ns |
| in_active_ns | input | TIME_W | Strobe active time, ns |
| in_cycle_ns | input | TIME_W | Full cycle time, ns |
| in_clk_ns | input | CLK_W | Bus clock period, ns, nonzero |
| in_rev | input | 2 | Silicon revision |
| in_drive | input | 2 | Drive index 0..3 |
| in_mate_present | input | 1 | Partner drive present |
| in_mate_setup | input | TIME_W+1 | Partner setup count |
| in_mate_active | input | 5 | Partner active count |
| in_mate_recovery | input | 5 | Partner recovery count |
| in_setup_keep | input | 6 | Current low six bits of the setup register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_setup_reg | output | 8 | Setup register byte |
| out_timing | output | 8 | Packed active/recovery byte |
| out_setup_cnt | output | TIME_W+1 | Own setup count |
| out_active_cnt | output | 5 | Own active count |
| out_recovery_cnt | output | 5 | Own recovery count |

## Verification
Every result arrives at a single fixed point in time. Four rounded-up divisions are run in sequence, each taking TIME_W+3 edges, and one more edge registers the outputs, so `out_valid` rises exactly 53 edges after the accepting edge. The bench counts rising edges from acceptance and samples on falling edges. It checks that `out_valid` first appears on edge 53, and it compares the bytes and counts only then. When output is held back, it samples every falling edge to confirm that nothing moves. A request injected mid-computation must leave the result equal to the first request's expected values.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_CALC,
    ST_OUT
  } calc_state_e;

  // Division slots, issued in this order
  localparam int SLOT_CYC  = 0;
  localparam int SLOT_SET  = 1;
  localparam int SLOT_ACT  = 2;
  localparam int SLOT_REC  = 3;
  localparam int N_SLOT    = 4;

  // Controller limits
  localparam int ACT_MIN   = 2;
  localparam int REC_MIN   = 2;
  localparam int REC_SPILL = 17;
  localparam int FIELD_MAX = 16;

  // Setup field codes (bits [7:6] of the setup register)
  localparam logic [1:0] SETUP_CODE_4    = 2'b00;
  localparam logic [1:0] SETUP_CODE_3    = 2'b10;
  localparam logic [1:0] SETUP_CODE_12   = 2'b01;
  localparam logic [1:0] SETUP_CODE_SLOW = 2'b11;

endpackage

// File: rtl/pio_seq_divider.sv
module pio_seq_divider #(
  parameter int N_W = 11,
  parameter int D_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [N_W-1:0] quotient
);

  localparam int CNT_W = $clog2(N_W);
  localparam int P_W   = N_W + D_W + 1;

  logic [N_W-1:0]   quo_r, dvd_r;
  logic [D_W-1:0]   rem_r, dvs_r;
  logic [CNT_W-1:0] cnt_r;
  logic             busy_r, done_r;

  logic [D_W:0] trial, diff;
  logic         take;

  assign trial = {rem_r, quo_r[N_W-1]};
  assign diff  = trial - {1'b0, dvs_r};
  assign take  = (trial >= {1'b0, dvs_r});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r  <= '0;
      dvd_r  <= '0;
      rem_r  <= '0;
      dvs_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else if (start) begin
      dvd_r  <= dividend;
      dvs_r  <= divisor;
      quo_r  <= dividend;
      rem_r  <= '0;
      cnt_r  <= CNT_W'(N_W - 1);
      busy_r <= 1'b1;
      done_r <= 1'b0;
    end else if (busy_r) begin
      rem_r <= take ? diff[D_W-1:0] : trial[D_W-1:0];
      quo_r <= {quo_r[N_W-2:0], take};
      if (cnt_r == '0) begin
        busy_r <= 1'b0;
        done_r <= 1'b1;
      end else begin
        cnt_r <= cnt_r - CNT_W'(1);
      end
    end else begin
      done_r <= 1'b0;
    end
  end

  assign done     = done_r;
  assign quotient = quo_r;

  logic [P_W-1:0] prod;
  assign prod = P_W'(quo_r) * P_W'(dvs_r);

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_r && dvs_r != '0) |->
      (prod <= P_W'(dvd_r)) && (prod + P_W'(dvs_r) > P_W'(dvd_r))); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r); // R8

endmodule

// File: rtl/pio_count_rules.sv
module pio_count_rules
  import pio_calc_pkg::*;
#(
  parameter int Q_W = 11,
  parameter int C_W = 5
) (
  input  logic [Q_W-1:0] q_cyc,
  input  logic [Q_W-1:0] q_set,
  input  logic [Q_W-1:0] q_act,
  input  logic [Q_W-1:0] q_rec,
  input  logic [1:0]     rev,
  input  logic [1:0]     drive,
  input  logic           mate_present,
  input  logic [Q_W-1:0] mate_set,
  input  logic [C_W-1:0] mate_act,
  input  logic [C_W-1:0] mate_rec,
  input  logic [5:0]     keep,
  output logic [Q_W-1:0] own_set,
  output logic [C_W-1:0] own_act,
  output logic [C_W-1:0] own_rec,
  output logic [7:0]     setup_reg,
  output logic [7:0]     timing
);

  localparam int X_W = Q_W + 2;
  localparam logic [X_W-1:0] L_ACT_MIN = X_W'(ACT_MIN);
  localparam logic [X_W-1:0] L_REC_MIN = X_W'(REC_MIN);
  localparam logic [X_W-1:0] L_SPILL   = X_W'(REC_SPILL);
  localparam logic [X_W-1:0] L_MAX     = X_W'(FIELD_MAX);

  logic [X_W-1:0] act_x, rec_x, rec2_x, sum_x, cyc_x;

  // Clamp, spill and revision adjustment of the drive's own counts
  always_comb begin
    cyc_x = X_W'(q_cyc);
    act_x = X_W'(q_act);
    if (act_x < L_ACT_MIN) act_x = L_ACT_MIN;
    sum_x  = X_W'(q_set) + act_x;
    rec2_x = (cyc_x > sum_x) ? (cyc_x - sum_x) : '0;
    rec_x  = X_W'(q_rec);
    if (rec2_x > rec_x) rec_x = rec2_x;
    if (rec_x < L_REC_MIN) rec_x = L_REC_MIN;
    if (rec_x > L_SPILL) begin
      act_x = act_x + (rec_x - L_SPILL);
      rec_x = L_SPILL;
    end
    if (act_x > L_MAX) act_x = L_MAX;
    if (rev > 2'd1) rec_x = rec_x - X_W'(1);
    if (rec_x > L_MAX) rec_x = L_MAX;
  end

  assign own_set = q_set;
  assign own_act = act_x[C_W-1:0];
  assign own_rec = rec_x[C_W-1:0];

  // Slowest-of-pair merge for the shared secondary registers
  logic           do_merge;
  logic [Q_W-1:0] m_set;
  logic [C_W-1:0] m_act, m_rec;

  assign do_merge = drive[1] && mate_present;

  always_comb begin
    m_set = own_set;
    m_act = own_act;
    m_rec = own_rec;
    if (do_merge) begin
      if (mate_set > m_set) m_set = mate_set;
      if (mate_act > m_act) m_act = mate_act;
      if (mate_rec > m_rec) m_rec = mate_rec;
    end
  end

  // Register byte encoding
  logic [1:0] set_code;

  always_comb begin
    if (m_set == Q_W'(4))                              set_code = SETUP_CODE_4;
    else if (m_set == Q_W'(3))                         set_code = SETUP_CODE_3;
    else if (m_set == Q_W'(1) || m_set == Q_W'(2))     set_code = SETUP_CODE_12;
    else                                               set_code = SETUP_CODE_SLOW;
  end

  assign setup_reg = {set_code, keep};
  assign timing    = {m_act[3:0], m_rec[3:0]};

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_calc_pkg::*;
#(
  parameter int TIME_W = 10,
  parameter int CLK_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [TIME_W-1:0]   in_setup_ns,
  input  logic [TIME_W-1:0]   in_active_ns,
  input  logic [TIME_W-1:0]   in_cycle_ns,
  input  logic [CLK_W-1:0]    in_clk_ns,
  input  logic [1:0]          in_rev,
  input  logic [1:0]          in_drive,
  input  logic                in_mate_present,
  input  logic [TIME_W:0]     in_mate_setup,
  input  logic [4:0]          in_mate_active,
  input  logic [4:0]          in_mate_recovery,
  input  logic [5:0]          in_setup_keep,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_setup_reg,
  output logic [7:0]          out_timing,
  output logic [TIME_W:0]     out_setup_cnt,
  output logic [4:0]          out_active_cnt,
  output logic [4:0]          out_recovery_cnt
);

  localparam int DIV_W = TIME_W + 1;
  localparam int C_W   = 5;
  localparam int IDX_W = $clog2(N_SLOT);

  calc_state_e state_r;
  logic [IDX_W-1:0] idx_r;

  // Latched request
  logic [TIME_W-1:0] t_ns_r [N_SLOT];
  logic [CLK_W-1:0]  t_clk_r;
  logic [1:0]        rev_r, drive_r;
  logic              mate_p_r;
  logic [DIV_W-1:0]  mate_s_r;
  logic [C_W-1:0]    mate_a_r, mate_r_r;
  logic [5:0]        keep_r;

  logic accept;
  assign accept = in_valid && (state_r == ST_IDLE);

  // Recovery time in ns, saturating at zero
  logic [TIME_W:0]   sa_sum;
  logic [TIME_W-1:0] rec_ns;
  assign sa_sum = {1'b0, in_setup_ns} + {1'b0, in_active_ns};
  assign rec_ns = ({1'b0, in_cycle_ns} > sa_sum) ?
                  TIME_W'({1'b0, in_cycle_ns} - sa_sum) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOT; i++) t_ns_r[i] <= '0;
      t_clk_r  <= '0;
      rev_r    <= '0;
      drive_r  <= '0;
      mate_p_r <= 1'b0;
      mate_s_r <= '0;
      mate_a_r <= '0;
      mate_r_r <= '0;
      keep_r   <= '0;
    end else if (accept) begin
      t_ns_r[SLOT_CYC] <= in_cycle_ns;
      t_ns_r[SLOT_SET] <= in_setup_ns;
      t_ns_r[SLOT_ACT] <= in_active_ns;
      t_ns_r[SLOT_REC] <= rec_ns;
      t_clk_r  <= in_clk_ns;
      rev_r    <= in_rev;
      drive_r  <= in_drive;
      mate_p_r <= in_mate_present;
      mate_s_r <= in_mate_setup;
      mate_a_r <= in_mate_active;
      mate_r_r <= in_mate_recovery;
      keep_r   <= in_setup_keep;
    end
  end

  // Shared divider: ceil(n/d) = floor((n + d - 1)/d)
  logic             div_start, div_done;
  logic [DIV_W-1:0] div_dividend, div_quo;

  assign div_start    = (state_r == ST_LOAD);
  assign div_dividend = DIV_W'(t_ns_r[idx_r]) + DIV_W'(t_clk_r) - DIV_W'(1);

  pio_seq_divider #(.N_W(DIV_W), .D_W(CLK_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (t_clk_r),
    .done     (div_done),
    .quotient (div_quo)
  );

  // Quotient slots
  logic [DIV_W-1:0] q_r [N_SLOT];
  logic             cap;
  assign cap = (state_r == ST_WAIT) && div_done;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q_r[g] <= '0;
      else if (cap && idx_r == IDX_W'(g))     q_r[g] <= div_quo;
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r <= ST_IDLE;
      idx_r   <= '0;
    end else begin
      unique case (state_r)
        ST_IDLE: if (accept) begin
          state_r <= ST_LOAD;
          idx_r   <= '0;
        end
        ST_LOAD: state_r <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          if (idx_r == IDX_W'(N_SLOT - 1)) state_r <= ST_CALC;
          else begin
            idx_r   <= idx_r + IDX_W'(1);
            state_r <= ST_LOAD;
          end
        end
        ST_CALC: state_r <= ST_OUT;
        ST_OUT:  if (out_ready) state_r <= ST_IDLE;
        default: state_r <= ST_IDLE;
      endcase
    end
  end

  // Count rules
  logic [DIV_W-1:0] r_set;
  logic [C_W-1:0]   r_act, r_rec;
  logic [7:0]       r_sreg, r_timing;

  pio_count_rules #(.Q_W(DIV_W), .C_W(C_W)) u_rules (
    .q_cyc        (q_r[SLOT_CYC]),
    .q_set        (q_r[SLOT_SET]),
    .q_act        (q_r[SLOT_ACT]),
    .q_rec        (q_r[SLOT_REC]),
    .rev          (rev_r),
    .drive        (drive_r),
    .mate_present (mate_p_r),
    .mate_set     (mate_s_r),
    .mate_act     (mate_a_r),
    .mate_rec     (mate_r_r),
    .keep         (keep_r),
    .own_set      (r_set),
    .own_act      (r_act),
    .own_rec      (r_rec),
    .setup_reg    (r_sreg),
    .timing       (r_timing)
  );

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_setup_reg    <= '0;
      out_timing       <= '0;
      out_setup_cnt    <= '0;
      out_active_cnt   <= '0;
      out_recovery_cnt <= '0;
    end else if (state_r == ST_CALC) begin
      out_setup_reg    <= r_sreg;
      out_timing       <= r_timing;
      out_setup_cnt    <= r_set;
      out_active_cnt   <= r_act;
      out_recovery_cnt <= r_rec;
    end
  end

  assign in_ready  = (state_r == ST_IDLE);
  assign out_valid = (state_r == ST_OUT);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_timing)
      && $stable(out_setup_reg) && $stable(out_setup_cnt)); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready && !out_valid); // R8

  AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_active_cnt >= 5'd2) && (out_active_cnt <= 5'd16)); // R3

  AST_REC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_recovery_cnt >= 5'd1) && (out_recovery_cnt <= 5'd16)); // R4

  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_r == ST_CALC) |=> out_setup_reg[5:0] == keep_r); // R6

endmodule

// File: tb/test_pio_timing_calc.sv
module test_pio_timing_calc;

  localparam int TIME_W = 10;
  localparam int CLK_W  = 6;
  localparam int LAT    = 4 * (TIME_W + 1) + 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TIME_W-1:0] in_setup_ns = '0, in_active_ns = '0, in_cycle_ns = '0;
  logic [CLK_W-1:0]  in_clk_ns = 6'd30;
  logic [1:0] in_rev = '0, in_drive = '0;
  logic in_mate_present = 1'b0;
  logic [TIME_W:0] in_mate_setup = '0;
  logic [4:0] in_mate_active = '0, in_mate_recovery = '0;
  logic [5:0] in_setup_keep = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_setup_reg, out_timing;
  logic [TIME_W:0] out_setup_cnt;
  logic [4:0] out_active_cnt, out_recovery_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #10 clk = ~clk;

  pio_timing_calc #(.TIME_W(TIME_W), .CLK_W(CLK_W)) i_pio_timing_calc (
    .clk, .rst_n, .in_valid, .in_ready, .in_setup_ns, .in_active_ns,
    .in_cycle_ns, .in_clk_ns, .in_rev, .in_drive, .in_mate_present,
    .in_mate_setup, .in_mate_active, .in_mate_recovery, .in_setup_keep,
    .out_valid, .out_ready, .out_setup_reg, .out_timing, .out_setup_cnt,
    .out_active_cnt, .out_recovery_cnt
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  // Expected values from the requirements
  task automatic model(input int s, a, c, k, rv, dr, pp, ps, pa, pr, kp,
                       output int os, oa, orc, sreg, tb);
    int cc, sc, ac, rt, rc, r2, ms, ma, mr, code;
    cc = cdiv(c, k); sc = cdiv(s, k); ac = cdiv(a, k);          // R1
    rt = (c > s + a) ? c - s - a : 0;
    rc = cdiv(rt, k);
    if (ac < 2) ac = 2;                                          // R2
    r2 = (cc > sc + ac) ? cc - sc - ac : 0;
    if (r2 > rc) rc = r2;
    if (rc < 2) rc = 2;
    if (rc > 17) begin ac = ac + rc - 17; rc = 17; end           // R3
    if (ac > 16) ac = 16;
    if (rv > 1) rc = rc - 1;                                     // R4
    if (rc > 16) rc = 16;
    os = sc; oa = ac; orc = rc;
    ms = sc; ma = ac; mr = rc;
    if (dr >= 2 && pp != 0) begin                                // R5
      if (ps > ms) ms = ps;
      if (pa > ma) ma = pa;
      if (pr > mr) mr = pr;
    end
    if (ms == 4) code = 0;                                       // R6
    else if (ms == 3) code = 2;
    else if (ms == 1 || ms == 2) code = 1;
    else code = 3;
    sreg = code * 64 + kp;
    tb = (ma % 16) * 16 + (mr % 16);                             // R7
  endtask

  task automatic run(input int s, a, c, k, rv, dr, pp, ps, pa, pr, kp, hold);
    int os, oa, orc, sreg, tb, n;
    logic [7:0] snap_t, snap_s;
    model(s, a, c, k, rv, dr, pp, ps, pa, pr, kp, os, oa, orc, sreg, tb);
    @(negedge clk);
    in_setup_ns = TIME_W'(s); in_active_ns = TIME_W'(a); in_cycle_ns = TIME_W'(c);
    in_clk_ns = CLK_W'(k); in_rev = 2'(rv); in_drive = 2'(dr);
    in_mate_present = pp[0]; in_mate_setup = (TIME_W+1)'(ps);
    in_mate_active = 5'(pa); in_mate_recovery = 5'(pr); in_setup_keep = 6'(kp);
    in_valid = 1'b1;
    chk("R8 ready before accept", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (hold != 0 && n == 3) begin
        // R8: request offered while busy must be ignored
        in_valid = 1'b1; in_cycle_ns = 10'd1000; in_setup_ns = 10'd0;
        in_clk_ns = 6'd1; in_setup_keep = ~in_setup_keep;
        chk("R8 in_ready low while busy", int'(in_ready), 0);
      end
      if (hold != 0 && n == 5) in_valid = 1'b0;
    end
    chk("R8 latency", n, LAT);
    chk("R6 setup byte", int'(out_setup_reg), sreg);
    chk((dr >= 2 && pp != 0) ? "R5/R7 timing byte" : "R7 timing byte", int'(out_timing), tb);
    chk("R1 own setup", int'(out_setup_cnt), os);
    chk("R3 own active", int'(out_active_cnt), oa);
    chk("R2/R4 own recovery", int'(out_recovery_cnt), orc);
    snap_t = out_timing; snap_s = out_setup_reg;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      chk("R9 valid held", int'(out_valid), 1);
      chk("R9 in_ready low", int'(in_ready), 0);
      chk("R9 timing stable", int'(out_timing), int'(snap_t));
      chk("R9 setup stable", int'(out_setup_reg), int'(snap_s));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 back to idle", int'(in_ready), 1);
  endtask

  initial begin
    int clks[3]  = '{8, 15, 30};
    int sets[4]  = '{0, 25, 70, 100};
    int acts[3]  = '{50, 165, 290};
    int cycs[5]  = '{120, 240, 383, 600, 1000};
    int pss[2]   = '{2, 5};
    int pas[2]   = '{3, 16};
    int prs[2]   = '{2, 16};
    repeat (3) @(negedge clk);
    chk("R10 reset in_ready", int'(in_ready), 1);
    chk("R10 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", int'(in_ready), 1);

    // Main sweep over clock, times and revision
    foreach (clks[ci]) foreach (sets[si]) foreach (acts[ai]) foreach (cycs[yi])
      for (int rv = 1; rv <= 2; rv++)
        run(sets[si], acts[ai], cycs[yi], clks[ci], rv, 0, 0, 0, 0, 0,
            (si * 13 + yi) % 64, 0);

    // Partner merge across all drive indices
    for (int dr = 0; dr < 4; dr++)
      for (int pp = 0; pp < 2; pp++)
        foreach (pss[a]) foreach (pas[b]) foreach (prs[c])
          for (int v = 0; v < 2; v++)
            run(v ? 30 : 70, v ? 80 : 290, v ? 240 : 600, v ? 30 : 15, 2, dr, pp,
                pss[a], pas[b], prs[c], 21, 0);

    // Setup encoding boundaries: counts 1..6 with a 10 ns clock
    for (int sc = 1; sc <= 6; sc++) run(sc * 10, 30, 200, 10, 1, 0, 0, 0, 0, 0, 63, 0);

    // Spill of recovery into active and field limits
    run(10, 20, 1000, 8, 1, 0, 0, 0, 0, 0, 5, 0);
    run(10, 20, 1000, 8, 2, 0, 0, 0, 0, 0, 5, 0);
    run(0, 0, 0, 30, 1, 0, 0, 0, 0, 0, 0, 0);
    run(1023, 1023, 1023, 1, 3, 3, 1, 2047, 16, 16, 42, 0);

    // Back-pressure with an ignored mid-run request
    run(70, 165, 383, 30, 2, 2, 1, 3, 5, 4, 9, 6);
    run(25, 290, 600, 15, 1, 1, 1, 9, 9, 9, 50, 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule